// File: doc/BRIEF.md
# Chainable FIFO Depth-Expansion Cell

This block is a small FIFO storage cell. Identical cells can be linked in a ring to form one FIFO that is deeper than any single cell. Every cell in the ring sees the same write strobe, write data, read strobe and reset. A cell acts on a shared strobe only while it owns the matching token. There is a write token and a read token. Each cell hands its tokens on to the next cell through one expansion output wire, and takes them from the previous cell on its expansion input.

After reset, the cell whose first-load input is low owns both tokens, and every other cell owns neither. When the owner of the write token fills its last physical location, it gives the write token to the next cell. When the owner of the read token drains its last physical location, it gives the read token to the next cell in the same way. In this mode the cell offers no retransmit and no half-full indication.

Each cell drives its own active-low empty and full flags. External logic combines them, so a composite flag is asserted whenever any one cell asserts its local flag. Each cell also drives its own registered read data with a valid qualifier, and the surrounding logic selects the cell that raised valid.

Top module: `fifo_chain_cell`

## Requirements
- R1: While reset is held, and just after it, a cell with `firstLoadN` low drives `emptyN`=0 and `fullN`=1. A cell with `firstLoadN` high drives `emptyN`=1 and `fullN`=1. Every cell drives `expOut`=0 and `rdValid`=0.
- R2: A write is stored only if the cell owns the write token and its occupancy is below DEPTH. A read is taken only if the cell owns the read token and its occupancy is above zero. Read data appears on `rdData`, with `rdValid`=1, in the cycle after the accepted read strobe.
- R3: `expOut` is 1 during the cycle in which an accepted write targets physical location DEPTH-1. At the end of that cycle the cell releases the write token.
- R4: `expOut` is 1 during the cycle in which an accepted read targets physical location DEPTH-1. At the end of that cycle the cell releases the read token.
- R5: Each pulse on `expIn` hands over one token, and the pulses alternate: the first after reset carries the write token, the next carries the read token, and so on. The pulse coincides with the matching shared strobe, and the cell owns that token from the next cycle.
- R6: `emptyN` is 0 only while the cell owns the read token and holds no words. `fullN` is 0 only while the cell owns the write token and holds DEPTH words. The composite flag (any local flag at 0) is exact for the whole ring.
- R7: A ring of N cells holds N*DEPTH words and returns them in write order. A write offered while the ring is full has no effect on later read data.
- R8: A read offered while the ring is empty produces no `rdValid` and leaves the order of the stored data unchanged.
- R9: A write and a read in the same cycle both take effect when the flags sampled before that clock edge allow them. When the ring is full, the read proceeds and the write is dropped.
- R10: Pointers wrap from DEPTH-1 to zero, so a returning write token finds location zero ready. Ordering holds over many laps of the ring.
- R11: Reset during operation discards every stored word and restores the token placement of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the ring |
| rstN | input | 1 | Asynchronous active-low reset, shared |
| firstLoadN | input | 1 | Low marks the cell that owns both tokens after reset |
| wrEn | input | 1 | Shared write strobe |
| wrData | input | DATA_W | Shared write data |
| rdEn | input | 1 | Shared read strobe |
| expIn | input | 1 | Token pulse from the previous cell |
| expOut | output | 1 | Token pulse to the next cell |
| rdData | output | DATA_W | Registered read data of this cell |
| rdValid | output | 1 | High in the cycle `rdData` carries a word read by this cell |
| emptyN | output | 1 | Local active-low empty flag |
| fullN | output | 1 | Local active-low full flag |

## Verification
The bench links three cells of DEPTH=4 and DATA_W=9 into a twelve-word ring, with cell 0 as first-load. Because the ring is so short, a few hundred cycles of arithmetic strobe patterns carry each token around it many times. Within reach are all three handoff points, both full and empty with simultaneous strobes, ignored writes and reads at the limits, and a reset in the middle of traffic. The bench predicts every `expOut` pulse from its running counts of accepted writes and reads.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // Accepted operations, issued by the control half to the storage half.
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } cellStrobe_t;

endpackage

// File: rtl/fifo_chain_store.sv
module fifo_chain_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fifo_chain_pkg::cellStrobe_t strobe,
  input  logic [DATA_W-1:0]           wrData,
  output logic                        wrAtLast,
  output logic                        rdAtLast,
  output logic [DATA_W-1:0]           rdData,
  output logic                        rdValid
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_LOC = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W-1:0]  wrPtrNext, rdPtrNext;
  logic [DATA_W-1:0] cells [DEPTH];

  // A power-of-two depth wraps by natural overflow; any other depth compares.
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrapPow2
      assign wrPtrNext = wrPtr + 1'b1;
      assign rdPtrNext = rdPtr + 1'b1;
    end else begin : g_wrapCmp
      assign wrPtrNext = (wrPtr == LAST_LOC) ? '0 : wrPtr + 1'b1;
      assign rdPtrNext = (rdPtr == LAST_LOC) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  assign wrAtLast = (wrPtr == LAST_LOC);
  assign rdAtLast = (rdPtr == LAST_LOC);

  always_ff @(posedge clk) begin
    if (strobe.doWrite) cells[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.doRead;
      if (strobe.doWrite) wrPtr <= wrPtrNext;
      if (strobe.doRead) begin
        rdPtr  <= rdPtrNext;
        rdData <= cells[rdPtr];
      end
    end
  end

  // R10: both pointers stay inside the physical locations
  p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= LAST_LOC) && (rdPtr <= LAST_LOC));

endmodule

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        firstLoadN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic                        expIn,
  input  logic                        wrAtLast,
  input  logic                        rdAtLast,
  output fifo_chain_pkg::cellStrobe_t strobe,
  output logic                        expOut,
  output logic                        emptyN,
  output logic                        fullN
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ;
  logic wrOwn, rdOwn;
  logic writeNext;      // next token to arrive on expIn is the write token
  logic wrHand, rdHand;
  logic takeWr, takeRd;
  logic cellFull, cellEmpty;

  assign cellFull  = (occ == OCC_MAX);
  assign cellEmpty = (occ == '0);

  assign strobe.doWrite = wrEn & wrOwn & ~cellFull;
  assign strobe.doRead  = rdEn & rdOwn & ~cellEmpty;

  assign wrHand = strobe.doWrite & wrAtLast;
  assign rdHand = strobe.doRead & rdAtLast;
  assign expOut = wrHand | rdHand;

  assign takeWr = expIn & writeNext;
  assign takeRd = expIn & ~writeNext;

  assign emptyN = ~(rdOwn & cellEmpty);
  assign fullN  = ~(wrOwn & cellFull);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ       <= '0;
      wrOwn     <= ~firstLoadN;
      rdOwn     <= ~firstLoadN;
      writeNext <= 1'b1;
    end else begin
      occ <= occ + OCC_W'(strobe.doWrite) - OCC_W'(strobe.doRead);
      if (takeWr)      wrOwn <= 1'b1;
      else if (wrHand) wrOwn <= 1'b0;
      if (takeRd)      rdOwn <= 1'b1;
      else if (rdHand) rdOwn <= 1'b0;
      if (expIn)       writeNext <= ~writeNext;
    end
  end

  // R6: occupancy never exceeds the physical depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_MAX);

  // R3: filling the last location gives the write token away
  p_wr_handoff_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doWrite && wrAtLast && !takeWr) |=> !wrOwn);

  // R4: draining the last location gives the read token away
  p_rd_handoff_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRead && rdAtLast && !takeRd) |=> !rdOwn);

  // R5: an arriving token coincides with the strobe of its own kind
  p_token_kind_r5: assert property (@(posedge clk) disable iff (!rstN)
    expIn |-> (writeNext ? wrEn : rdEn));

  // R5: an arriving write token never finds the cell already owning it
  p_wr_token_fresh_r5: assert property (@(posedge clk) disable iff (!rstN)
    takeWr |-> !wrOwn);

endmodule

// File: rtl/fifo_chain_cell.sv
module fifo_chain_cell #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              firstLoadN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              expIn,
  output logic              expOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              emptyN,
  output logic              fullN
);
  fifo_chain_pkg::cellStrobe_t strobe;
  logic wrAtLast, rdAtLast;

  fifo_chain_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN),
    .wrEn(wrEn), .rdEn(rdEn), .expIn(expIn),
    .wrAtLast(wrAtLast), .rdAtLast(rdAtLast),
    .strobe(strobe), .expOut(expOut), .emptyN(emptyN), .fullN(fullN)
  );

  fifo_chain_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wrAtLast(wrAtLast), .rdAtLast(rdAtLast),
    .rdData(rdData), .rdValid(rdValid)
  );

  // R8: an empty cell does not produce read data on the next cycle
  p_no_read_when_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    !emptyN |=> !rdValid);

endmodule

// File: tb/fifo_chain_cell_tb.sv
module fifo_chain_cell_tb;
  localparam int DATA_W = 9;
  localparam int DEPTH  = 4;
  localparam int NCELL  = 3;
  localparam int RING   = NCELL * DEPTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [NCELL-1:0] expOut, emptyN, fullN, rdValid;
  logic [DATA_W-1:0] rdDataA [NCELL];

  always #5 clk = ~clk;

  for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
    fifo_chain_cell #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rstN(rstN), .firstLoadN(gi != 0),
      .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
      .expIn(expOut[(gi + NCELL - 1) % NCELL]), .expOut(expOut[gi]),
      .rdData(rdDataA[gi]), .rdValid(rdValid[gi]),
      .emptyN(emptyN[gi]), .fullN(fullN[gi])
    );
  end

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] model [$];
  logic [DATA_W-1:0] nextData = '0;
  logic [DATA_W-1:0] pendData = '0;
  bit pendValid = 1'b0;
  int wc = 0, rc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] mergedData();
    logic [DATA_W-1:0] acc = '0;
    for (int i = 0; i < NCELL; i++) if (rdValid[i]) acc |= rdDataA[i];
    return acc;
  endfunction

  task automatic step(input bit w, input bit r);
    bit expEmpty, expFull, accW, accR;
    logic [NCELL-1:0] expPulse;
    @(negedge clk);
    // result of the previous cycle's read (R2, R8)
    chk($countones(rdValid) <= 1, "R2 single source", $countones(rdValid), 1);
    chk((|rdValid) == pendValid, "R2 R8 rdValid", int'(|rdValid), int'(pendValid));
    if (pendValid)
      chk(mergedData() == pendData, "R2 R5 R7 R9 R10 order", mergedData(), pendData);
    wrEn = w; rdEn = r; wrData = nextData;
    #1;
    expEmpty = (model.size() == 0);
    expFull  = (model.size() == RING);
    chk((~&emptyN) == expEmpty, "R6 composite empty", int'(~&emptyN), int'(expEmpty));
    chk((~&fullN) == expFull, "R6 composite full", int'(~&fullN), int'(expFull));
    accW = w && !expFull;
    accR = r && !expEmpty;
    expPulse = '0;
    if (accW && (wc % DEPTH) == DEPTH - 1) expPulse[(wc / DEPTH) % NCELL] = 1'b1;
    if (accR && (rc % DEPTH) == DEPTH - 1) expPulse[(rc / DEPTH) % NCELL] = 1'b1;
    chk(expOut == expPulse, "R3 R4 expOut", expOut, expPulse);
    pendValid = accR;
    if (accR) begin pendData = model.pop_front(); rc++; end
    if (accW) begin model.push_back(nextData); wc++; end
    nextData = nextData + 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    #1;
    chk(emptyN == 3'b110, "R1 R11 emptyN in reset", emptyN, 3'b110);
    chk(fullN == 3'b111, "R1 R11 fullN in reset", fullN, 3'b111);
    chk(expOut == 3'b000, "R1 expOut in reset", expOut, 0);
    chk(rdValid == 3'b000, "R1 rdValid in reset", rdValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    model.delete(); pendValid = 1'b0; wc = 0; rc = 0;
    #1;
    chk(emptyN == 3'b110, "R1 emptyN after reset", emptyN, 3'b110);
    chk(fullN == 3'b111, "R1 fullN after reset", fullN, 3'b111);
  endtask

  initial begin
    doReset();
    // fill past capacity: last write ignored (R7)
    for (int i = 0; i < RING + 1; i++) step(1'b1, 1'b0);
    // simultaneous strobes while full (R9)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    // drain past empty: extra reads ignored (R8)
    for (int i = 0; i < RING + 2; i++) step(1'b0, 1'b1);
    // simultaneous strobes while empty (R9)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    // arithmetic strobe sweeps over many laps (R5, R10)
    for (int p = 0; p < 6; p++) begin
      if (p == 3) begin
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        doReset();  // R11: mid-traffic reset
      end
      for (int i = 0; i < 300; i++)
        step(((i + p) % (p + 2)) != 0, ((i * 3 + p) % (p + 3)) < 2);
    end
    for (int i = 0; i < RING + 2; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule